// File: doc/BRIEF.md
# Power Mode Controller with Write-Once Protection

This block manages entry into low-power run and stop modes. Software reaches it through a small byte-wide register bus with address, write data, write enable, read enable and read data. There are four registers: a protection byte, a mode control byte, a stop control byte and a read-only status byte.

The protection byte can be written only once after a chip-level reset. It sets which low-power modes may be requested. A run-mode request that protection does not allow is refused without any signal, and the run-mode field keeps its old value. The status byte reports the current mode as a one-hot code.

A sleep-request strobe from the processor side is turned into a one-cycle low-power-entry pulse. The request is taken only in a cycle with no register write on the bus.

There are two resets:
- `rst_ni` is the chip-level reset. It is asynchronous and active low, and it clears everything.
- `warm_rst_i` is a synchronous reset of lower severity. It leaves the protection byte and its lock untouched.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After chip reset, reads at offsets 0, 1, 2 and 3 return 0x00, 0x00, 0x03 and 0x01.
- R2: Writes to offset 3 (status) have no effect on its read value.
- R3: Only the first write to offset 0 after chip reset is stored. Later writes are discarded until the next chip reset, and a chip reset re-arms the write.
- R4: A warm reset returns mode control to 0x00, stop control to 0x03 and status to 0x01. It leaves the protection byte and its write lock unchanged.
- R5: The run-mode field is mode-control bits 6:5, with 00 for normal run and 10 for very-low-power run. Writing 10 while protection bit 5 is 1 is accepted, so offset 1 reads 0x40. Writing 00 is always accepted.
- R6: Writing run-mode 10 while protection bit 5 is 0 is refused, and the field stays at its previous value.
- R7: Writes of the reserved run-mode codes 01 and 11 are refused, and the field keeps its value.
- R8: Status is 0x01 in normal run and 0x04 in very-low-power run. It changes one clock cycle after the run-mode field changes.
- R9: Stop control is a plain 8-bit read/write register.
- R10: A sleep request taken in a cycle with we_i low gives lp_entry_o high for exactly one cycle, in the next cycle. A held request gives only one pulse.
- R11: A sleep request seen while we_i is high is deferred to the first cycle without a write.
- R12: rdata_o is 0x00 whenever re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Chip-level reset, asynchronous, active low |
| warm_rst_i | input | 1 | Lower-severity reset, synchronous, active high |
| addr_i | input | 2 | Register byte offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sleep_req_i | input | 1 | Sleep request strobe |
| lp_entry_o | output | 1 | Low-power-entry pulse |

## Verification
Register writes land on the clock edge that ends the write cycle. Read data is combinational, so a read in the next cycle already shows a new control value. Status trails the run-mode field by one more edge. The bench therefore checks status both in the cycle right after a mode write, where the old code is expected, and one cycle later, where the new code is expected. lp_entry_o is a registered output, so it is sampled just before the second edge after the request is driven, and again one cycle later to confirm that it has fallen.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NREG   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] OFF_PROT = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_STOP = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_STAT = 2'd3;

  localparam int unsigned VLP_ALLOW_BIT = 5;
  localparam int unsigned RUN_LSB       = 5;

  localparam logic [REG_W-1:0] RST_PROT = 8'h00;
  localparam logic [REG_W-1:0] RST_STOP = 8'h03;
  localparam logic [REG_W-1:0] ST_RUN   = 8'h01;
  localparam logic [REG_W-1:0] ST_VLP   = 8'h04;

  typedef enum logic [1:0] {
    RUN_NORMAL = 2'b00,
    RUN_RSV1   = 2'b01,
    RUN_VLP    = 2'b10,
    RUN_RSV3   = 2'b11
  } run_mode_e;
endpackage

// File: rtl/pmc_prot.sv
module pmc_prot
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] prot_o,
  output logic             lock_o
);
  // chip reset only; warm reset deliberately absent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_o <= RST_PROT;
      lock_o <= 1'b0;
    end else if (wr_i && !lock_o) begin
      prot_o <= wdata_i;
      lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pmc_mode.sv
module pmc_mode
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             vlp_allow_i,
  output run_mode_e        run_o,
  output logic [REG_W-1:0] status_o
);
  run_mode_e        req;
  logic             accept;
  logic [REG_W-1:0] status_d;

  always_comb begin
    req = run_mode_e'(wdata_i[RUN_LSB +: 2]);
    unique case (req)
      RUN_NORMAL: accept = 1'b1;
      RUN_VLP:    accept = vlp_allow_i;
      default:    accept = 1'b0;
    endcase
  end

  always_comb begin
    unique case (run_o)
      RUN_VLP: status_d = ST_VLP;
      default: status_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= RUN_NORMAL;
      status_o <= ST_RUN;
    end else if (warm_i) begin
      run_o    <= RUN_NORMAL;
      status_o <= ST_RUN;
    end else begin
      if (wr_i && accept) run_o <= req;
      status_o <= status_d;
    end
  end
endmodule

// File: rtl/pmc_lpe.sv
module pmc_lpe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_i,
  input  logic sleep_req_i,
  input  logic wr_busy_i,
  output logic lp_entry_o
);
  logic armed_q;
  logic take;

  assign take = sleep_req_i && !wr_busy_i && !armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      lp_entry_o <= 1'b0;
    end else if (warm_i) begin
      armed_q    <= 1'b0;
      lp_entry_o <= 1'b0;
    end else begin
      lp_entry_o <= take;
      // one pulse per request assertion
      armed_q    <= sleep_req_i && (armed_q || take);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic          sleep_req_i,
  output logic          lp_entry_o
);
  localparam int unsigned NR = 1 << AW;

  logic [NR-1:0] wr_sel;
  logic [DW-1:0] reg_rd [NR];
  logic [DW-1:0] prot_q;
  logic          lock_q;
  run_mode_e     run_q;
  logic [DW-1:0] status_q;
  logic [DW-1:0] stop_q;
  logic [DW-1:0] mode_rd;

  for (genvar gi = 0; gi < NR; gi++) begin : g_dec
    assign wr_sel[gi] = we_i && (addr_i == AW'(gi));
  end

  pmc_prot u_prot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel[OFF_PROT]),
    .wdata_i (wdata_i),
    .prot_o  (prot_q),
    .lock_o  (lock_q)
  );

  pmc_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_i      (warm_rst_i),
    .wr_i        (wr_sel[OFF_MODE]),
    .wdata_i     (wdata_i),
    .vlp_allow_i (prot_q[VLP_ALLOW_BIT]),
    .run_o       (run_q),
    .status_o    (status_q)
  );

  pmc_lpe u_lpe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_i      (warm_rst_i),
    .sleep_req_i (sleep_req_i),
    .wr_busy_i   (we_i),
    .lp_entry_o  (lp_entry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stop_q <= RST_STOP;
    else if (warm_rst_i)        stop_q <= RST_STOP;
    else if (wr_sel[OFF_STOP])  stop_q <= wdata_i;
  end

  always_comb begin
    mode_rd = '0;
    mode_rd[RUN_LSB +: 2] = run_q;
  end

  assign reg_rd[OFF_PROT] = prot_q;
  assign reg_rd[OFF_MODE] = mode_rd;
  assign reg_rd[OFF_STOP] = stop_q;
  assign reg_rd[OFF_STAT] = status_q;

  assign rdata_o = re_i ? reg_rd[addr_i] : '0;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       warm_rst_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       lp_entry_o,
  input logic [7:0] prot_q,
  input logic       lock_q,
  input logic [1:0] run_q,
  input logic [7:0] status_q
);
  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  p_prot_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(prot_q));

  p_vlp_needs_allow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_q[5] |-> run_q != 2'b10);

  p_reserved_refused_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && wdata_i[5] && !warm_rst_i) |=> $stable(run_q));

  p_status_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_q) == 1);

  p_status_vlp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 2'b10 && !warm_rst_i) |=> status_q == 8'h04);

  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_entry_o |=> !lp_entry_o);

  p_no_take_on_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !lp_entry_o);
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .warm_rst_i (warm_rst_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .lp_entry_o (lp_entry_o),
  .prot_q     (prot_q),
  .lock_q     (lock_q),
  .run_q      (run_q),
  .status_q   (status_q)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       warm_rst_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;
  logic       sleep_req_i = 1'b0;
  logic       lp_entry_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  pwr_mode_ctrl uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_i  (warm_rst_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .re_i        (re_i),
    .rdata_o     (rdata_o),
    .sleep_req_i (sleep_req_i),
    .lp_entry_o  (lp_entry_o)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd1},  // R1
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'd1},
    '{1'b0, 2'd2, 8'h00, 8'h03, 4'd1},
    '{1'b0, 2'd3, 8'h00, 8'h01, 4'd1},
    '{1'b1, 2'd1, 8'h40, 8'h00, 4'd6},  // R6: vlp without allow
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'd6},
    '{1'b1, 2'd3, 8'hff, 8'h00, 4'd2},  // R2
    '{1'b0, 2'd3, 8'h00, 8'h01, 4'd2},
    '{1'b1, 2'd2, 8'ha5, 8'h00, 4'd9},  // R9
    '{1'b0, 2'd2, 8'h00, 8'ha5, 4'd9},
    '{1'b1, 2'd0, 8'h20, 8'h00, 4'd3},  // R3 first write
    '{1'b0, 2'd0, 8'h00, 8'h20, 4'd3},
    '{1'b1, 2'd0, 8'h00, 8'h00, 4'd3},  // R3 second write dropped
    '{1'b0, 2'd0, 8'h00, 8'h20, 4'd3},
    '{1'b1, 2'd1, 8'h20, 8'h00, 4'd7},  // R7 code 01
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'd7},
    '{1'b1, 2'd1, 8'h60, 8'h00, 4'd7},  // R7 code 11
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'd7},
    '{1'b1, 2'd1, 8'h40, 8'h00, 4'd5},  // R5 allowed vlp
    '{1'b0, 2'd1, 8'h00, 8'h40, 4'd5},
    '{1'b0, 2'd3, 8'h00, 8'h04, 4'd8},  // R8
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd5},  // R5 back to run
    '{1'b0, 2'd1, 8'h00, 8'h00, 4'd5}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; re_i = 1'b0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b1; addr_i = a;
    #2;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      we_i = VECS[i].wr; re_i = !VECS[i].wr;
      addr_i = VECS[i].addr; wdata_i = VECS[i].data;
      #2;
      if (!VECS[i].wr) chk($sformatf("R%0d vec%0d", VECS[i].req, i), rdata_o, VECS[i].exp);
    end
    @(negedge clk_i); we_i = 1'b0; re_i = 1'b0;

    // R8: status lags run field by one cycle
    wr(2'd1, 8'h40);
    re_i = 1'b1; addr_i = 2'd3;
    #2 chk("R8 lag", rdata_o, 8'h01);
    rd(2'd3, 8'h04, "R8 updated");

    // R4: warm reset
    wr(2'd2, 8'h5a);
    @(negedge clk_i); warm_rst_i = 1'b1;
    @(negedge clk_i); warm_rst_i = 1'b0;
    rd(2'd0, 8'h20, "R4 prot kept");
    rd(2'd1, 8'h00, "R4 mode");
    rd(2'd2, 8'h03, "R4 stop");
    rd(2'd3, 8'h01, "R4 status");
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h20, "R4 lock kept");

    // R1 / R3: chip reset re-arms the write
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd0, 8'h00, "R1 prot");
    rd(2'd2, 8'h03, "R1 stop");
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h20);
    rd(2'd0, 8'h00, "R3 relock");
    wr(2'd1, 8'h40);
    rd(2'd1, 8'h00, "R6 locked off");

    // R12
    @(negedge clk_i); re_i = 1'b0; addr_i = 2'd2;
    #2 chk("R12 idle", rdata_o, 8'h00);

    // R10: held request, single pulse
    @(negedge clk_i); sleep_req_i = 1'b1;
    @(negedge clk_i); #2 chk("R10 pulse", {7'd0, lp_entry_o}, 8'h01);
    @(negedge clk_i); #2 chk("R10 fall", {7'd0, lp_entry_o}, 8'h00);
    @(negedge clk_i); #2 chk("R10 held", {7'd0, lp_entry_o}, 8'h00);
    sleep_req_i = 1'b0;
    @(negedge clk_i); #2 chk("R10 idle", {7'd0, lp_entry_o}, 8'h00);

    // R11: request during write is deferred
    @(negedge clk_i);
    sleep_req_i = 1'b1; we_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h11;
    @(negedge clk_i); we_i = 1'b0;
    #2 chk("R11 blocked", {7'd0, lp_entry_o}, 8'h00);
    @(negedge clk_i); #2 chk("R11 deferred", {7'd0, lp_entry_o}, 8'h01);
    sleep_req_i = 1'b0;
    rd(2'd2, 8'h11, "R9 stop write");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule